// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O peripheral. Its pins are grouped into register sets of 32 pins each. Within a set, software chooses the direction of each pin. It moves the output latch only through write-one-to-set and write-one-to-clear registers, so no read-modify-write is needed. It reads back the pin level after a two-flop synchronizer.

Every pin can flag a rising edge, a falling edge, or both. Each of these enables is changed through its own set and clear register pair. A detected edge that is enabled latches a status bit, and software clears that bit by writing a one to it.

Status bits are grouped into 16-pin interrupt banks, two banks per register set. A global bank-enable register decides which banks drive their interrupt line. The bus is a single-cycle port: a write takes effect at the next clock edge, and read data appears one cycle after the read strobe, together with a valid flag.

Top module: `gpio_edge_banks`

## Requirements
- R1: After synchronous reset, every direction bit is 1 (input), so `pin_oe` is all zero. The output latch, all edge enables, all status bits, the bank-enable register and `irq` are zero.
- R2: A write to set-data (set offset 0x08) drives high the output bits whose mask bit is 1. A write to clear-data (offset 0x0C) drives those bits low. Mask bits of 0 leave their outputs unchanged. Reading offsets 0x04, 0x08 or 0x0C returns the current output latch.
- R3: The direction register (set offset 0x00) is read/write, with 1 meaning input. `pin_oe` for a pin is the inverse of its direction bit.
- R4: The input-data register (offset 0x10) returns the pin level through a two-stage synchronizer, regardless of direction. A read issued in the same cycle as a pin change, or in the cycle after it, still returns the old level. A read issued two cycles after the change returns the new level.
- R5: Rising-edge enables change through set-rise (0x14) and clear-rise (0x18). Falling-edge enables change through set-fall (0x1C) and clear-fall (0x20). Reading either register of a pair returns that enable vector.
- R6: A synchronized 0-to-1 transition on a pin whose rising enable is set latches its status bit. The same holds for a 1-to-0 transition with the falling enable set. A transition whose enable is clear leaves status unchanged.
- R7: Writing to the status register (offset 0x24) clears exactly the bits written as 1. Bits written as 0 are kept.
- R8: When a status clear and a new enabled edge hit the same bit at the same clock edge, the bit stays set.
- R9: Interrupt bank b covers status bits 16*(b%2) to 16*(b%2)+15 of set b/2. `irq[b]` is a registered signal: it is the OR of those status bits ANDed with bank-enable bit b, one cycle late.
- R10: The bank-enable register sits at offset 0x08, with bit k enabling bank k. Register set n starts at 0x10 + 0x28*n. Pin p maps to set p/32, bit p%32. A read returns data with `bus_rvalid` high exactly one cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | SET_W | Write data / bit mask |
| bus_rdata | output | SET_W | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| pin_in | input | NUM_SETS*SET_W | Asynchronous pin levels |
| pin_out | output | NUM_SETS*SET_W | Output latch |
| pin_oe | output | NUM_SETS*SET_W | Output enable (1 = drive) |
| irq | output | NUM_SETS*SET_W/BANK_W | One interrupt line per 16-pin bank |

## Verification
The hardest case to reach from the ports is a status clear landing on the same clock edge at which a new edge on the same pin is detected. Detection trails the pin change by the two synchronizer stages plus the previous-sample register. The bench therefore toggles the pin at a known falling clock edge and then idles exactly two cycles. The clear write is then sampled on the third rising edge, which is the detection edge, and a second clear one cycle later shows that the bit does clear when no edge competes. The synchronizer latency is pinned down in the same way: back-to-back reads start in the cycle of the pin change, and the new level is expected only on the third read.

// File: rtl/gpiob_pkg.sv
package gpiob_pkg;
  // Global register offsets and register-set placement
  localparam int BANKEN_OFF = 'h08;
  localparam int SET_FIRST  = 'h10;
  localparam int SET_SPAN   = 'h28;

  // Offsets within one register set
  localparam int OFF_DIR    = 'h00;
  localparam int OFF_OUT    = 'h04;
  localparam int OFF_OSET   = 'h08;
  localparam int OFF_OCLR   = 'h0C;
  localparam int OFF_IN     = 'h10;
  localparam int OFF_RSET   = 'h14;
  localparam int OFF_RCLR   = 'h18;
  localparam int OFF_FSET   = 'h1C;
  localparam int OFF_FCLR   = 'h20;
  localparam int OFF_STAT   = 'h24;

  function automatic int set_base(input int n);
    return SET_FIRST + SET_SPAN * n;
  endfunction
endpackage

// File: rtl/gpiob_sync.sv
module gpiob_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpiob_regset.sv
module gpiob_regset
  import gpiob_pkg::*;
#(
  parameter int SET_W       = 32,
  parameter int ADDR_W      = 8,
  parameter int BASE        = 'h10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SET_W-1:0]  wdata,
  input  logic [SET_W-1:0]  pin_in,
  output logic [SET_W-1:0]  rdata,
  output logic [SET_W-1:0]  dir_o,
  output logic [SET_W-1:0]  out_o,
  output logic [SET_W-1:0]  stat_o
);
  logic              hit;
  logic [ADDR_W-1:0] off;
  logic [SET_W-1:0]  sync_v, prev_q;
  logic [SET_W-1:0]  dir_q, out_q, rise_q, fall_q, stat_q;
  logic [SET_W-1:0]  edge_hit, clr_mask;

  assign hit = ({1'b0, addr} >= (ADDR_W+1)'(BASE)) &&
               ({1'b0, addr} <  (ADDR_W+1)'(BASE + SET_SPAN));
  assign off = addr - ADDR_W'(BASE);

  function automatic logic wr_at(input int o);
    return wr_en && hit && (off == ADDR_W'(o));
  endfunction

  gpiob_sync #(.W(SET_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_in),
    .dout (sync_v)
  );

  assign edge_hit = (sync_v & ~prev_q & rise_q) | (~sync_v & prev_q & fall_q);
  assign clr_mask = wr_at(OFF_STAT) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      dir_q  <= '1;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= sync_v;
      if (wr_at(OFF_DIR))  dir_q  <= wdata;
      if (wr_at(OFF_OSET)) out_q  <= out_q | wdata;
      if (wr_at(OFF_OCLR)) out_q  <= out_q & ~wdata;
      if (wr_at(OFF_RSET)) rise_q <= rise_q | wdata;
      if (wr_at(OFF_RCLR)) rise_q <= rise_q & ~wdata;
      if (wr_at(OFF_FSET)) fall_q <= fall_q | wdata;
      if (wr_at(OFF_FCLR)) fall_q <= fall_q & ~wdata;
      // a fresh edge overrides a simultaneous clear
      stat_q <= (stat_q & ~clr_mask) | edge_hit;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      case (off)
        ADDR_W'(OFF_DIR):  rdata = dir_q;
        ADDR_W'(OFF_OUT),
        ADDR_W'(OFF_OSET),
        ADDR_W'(OFF_OCLR): rdata = out_q;
        ADDR_W'(OFF_IN):   rdata = sync_v;
        ADDR_W'(OFF_RSET),
        ADDR_W'(OFF_RCLR): rdata = rise_q;
        ADDR_W'(OFF_FSET),
        ADDR_W'(OFF_FCLR): rdata = fall_q;
        ADDR_W'(OFF_STAT): rdata = stat_q;
        default:           rdata = '0;
      endcase
    end
  end

  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/gpiob_irq.sv
module gpiob_irq #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_BANKS*BANK_W-1:0] stat_all,
  input  logic [NUM_BANKS-1:0]        bank_en,
  output logic [NUM_BANKS-1:0]        irq
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) irq[b] <= 1'b0;
      else     irq[b] <= bank_en[b] & (|stat_all[b*BANK_W +: BANK_W]);
    end
  end
endmodule

// File: rtl/gpio_edge_banks.sv
module gpio_edge_banks
  import gpiob_pkg::*;
#(
  parameter int NUM_SETS    = 2,
  parameter int SET_W       = 32,
  parameter int BANK_W      = 16,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [SET_W-1:0]             bus_wdata,
  output logic [SET_W-1:0]             bus_rdata,
  output logic                         bus_rvalid,
  input  logic [NUM_SETS*SET_W-1:0]    pin_in,
  output logic [NUM_SETS*SET_W-1:0]    pin_out,
  output logic [NUM_SETS*SET_W-1:0]    pin_oe,
  output logic [NUM_SETS*SET_W/BANK_W-1:0] irq
);
  localparam int NUM_PINS  = NUM_SETS * SET_W;
  localparam int NUM_BANKS = NUM_PINS / BANK_W;

  logic [SET_W-1:0]     set_rd [NUM_SETS];
  logic [NUM_PINS-1:0]  dir_all, stat_all;
  logic [NUM_BANKS-1:0] bank_en_q;
  logic                 banken_hit;
  logic [SET_W-1:0]     rd_mux;

  for (genvar n = 0; n < NUM_SETS; n++) begin : g_set
    gpiob_regset #(
      .SET_W       (SET_W),
      .ADDR_W      (ADDR_W),
      .BASE        (set_base(n)),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_set (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (bus_wr),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .pin_in (pin_in[n*SET_W +: SET_W]),
      .rdata  (set_rd[n]),
      .dir_o  (dir_all[n*SET_W +: SET_W]),
      .out_o  (pin_out[n*SET_W +: SET_W]),
      .stat_o (stat_all[n*SET_W +: SET_W])
    );
  end

  assign pin_oe     = ~dir_all;
  assign banken_hit = (bus_addr == ADDR_W'(BANKEN_OFF));

  always_ff @(posedge clk) begin
    if (rst)                      bank_en_q <= '0;
    else if (bus_wr && banken_hit) bank_en_q <= bus_wdata[NUM_BANKS-1:0];
  end

  always_comb begin
    rd_mux = banken_hit ? SET_W'(bank_en_q) : '0;
    for (int n = 0; n < NUM_SETS; n++) rd_mux = rd_mux | set_rd[n];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  gpiob_irq #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .stat_all (stat_all),
    .bank_en  (bank_en_q),
    .irq      (irq)
  );
endmodule

// File: rtl/gpio_edge_banks_chk.sv
module gpio_edge_banks_chk #(
  parameter int NUM_PINS  = 64,
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic                 bus_rvalid,
  input logic [NUM_PINS-1:0]  pin_out,
  input logic [NUM_BANKS-1:0] irq,
  input logic [NUM_PINS-1:0]  stat_all,
  input logic [NUM_BANKS-1:0] bank_en
);
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq == '0 && stat_all == '0 && pin_out == '0)); // R1

  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_wr) |-> $stable(pin_out)); // R2

  AST_STATUS_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_wr) |-> ((stat_all & $past(stat_all)) == $past(stat_all))); // R7

  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid); // R10

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
      irq[b] |-> ($past(bank_en[b]) && $past(|stat_all[b*BANK_W +: BANK_W]))); // R9
  end
endmodule

bind gpio_edge_banks gpio_edge_banks_chk #(
  .NUM_PINS  (NUM_PINS),
  .NUM_BANKS (NUM_BANKS),
  .BANK_W    (BANK_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_rvalid (bus_rvalid),
  .pin_out    (pin_out),
  .irq        (irq),
  .stat_all   (stat_all),
  .bank_en    (bank_en_q)
);

// File: tb/gpio_edge_banks_tb.sv
module gpio_edge_banks_tb;
  localparam int NS = 2, SW = 32, AW = 8, NB = 4;

  logic          clk = 0, rst = 1;
  logic          bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [SW-1:0] bus_wdata = '0;
  logic [SW-1:0] bus_rdata;
  logic          bus_rvalid;
  logic [63:0]   pin_in = '0;
  logic [63:0]   pin_out, pin_oe;
  logic [NB-1:0] irq;

  int n_tests = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  gpio_edge_banks u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  function automatic logic [AW-1:0] ra(input int s, input int o);
    return AW'(16 + 40 * s + o);
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R10: unexpected read data actual %h expected none", bus_rdata);
      end else begin
        check(64'(bus_rdata), 64'(exp_q.pop_front()), tag_q.pop_front());
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(5);
    rst = 0;
    idle(1);
    // R1 reset state
    check(64'(irq), 64'h0, "R1 irq");
    check(pin_oe, 64'h0, "R1 pin_oe");
    check(pin_out, 64'h0, "R1 pin_out");
    rd(ra(0, 'h00), 32'hFFFF_FFFF, "R1 dir set0");
    rd(ra(1, 'h00), 32'hFFFF_FFFF, "R1 dir set1");
    rd(ra(0, 'h24), 32'h0, "R1 status");
    rd(ra(0, 'h14), 32'h0, "R1 rise enable");
    rd(8'h08, 32'h0, "R1 bank enable");

    // R2 output latch via set/clear
    wr(ra(0, 'h08), 32'h0000_00F0);
    wr(ra(0, 'h08), 32'h0000_0003);
    rd(ra(0, 'h04), 32'h0000_00F3, "R2 set keeps other bits");
    wr(ra(0, 'h0C), 32'h0000_0030);
    rd(ra(0, 'h0C), 32'h0000_00C3, "R2 clear via clr register read");
    wr(ra(1, 'h08), 32'h8000_0001);
    check(pin_out, 64'h8000_0001_0000_00C3, "R2 R10 pin_out mapping");

    // R3 direction
    wr(ra(0, 'h00), 32'hFFFF_0000);
    wr(ra(1, 'h00), 32'h0000_0000);
    check(pin_oe, 64'hFFFF_FFFF_0000_FFFF, "R3 pin_oe");
    rd(ra(0, 'h00), 32'hFFFF_0000, "R3 dir readback");

    // R4 synchronized input readback and latency
    pin_in = 64'hA5A5_0F0F_1234_5678;
    rd(ra(0, 'h10), 32'h0, "R4 same-cycle read old");
    rd(ra(0, 'h10), 32'h0, "R4 next-cycle read old");
    rd(ra(0, 'h10), 32'h1234_5678, "R4 new level");
    rd(ra(1, 'h10), 32'hA5A5_0F0F, "R4 R10 output pins read level");
    pin_in = '0;
    idle(5);

    // R5 edge enables
    wr(ra(0, 'h14), 32'h0000_0018);
    wr(ra(0, 'h18), 32'h0000_0010);
    rd(ra(0, 'h18), 32'h0000_0008, "R5 rise enable pair");
    wr(ra(0, 'h1C), 32'h0010_0000);
    rd(ra(0, 'h1C), 32'h0010_0000, "R5 fall enable");

    // R6 edge detection
    pin_in[3] = 1; pin_in[5] = 1; pin_in[20] = 1;
    idle(5);
    rd(ra(0, 'h24), 32'h0000_0008, "R6 rising only where enabled");
    pin_in[20] = 0;
    idle(5);
    rd(ra(0, 'h24), 32'h0010_0008, "R6 falling edge");

    // R9 bank gating
    check(64'(irq), 64'h0, "R9 disabled banks");
    wr(8'h08, 32'h1);
    idle(2);
    check(64'(irq), 64'h1, "R9 bank0 only");
    wr(8'h08, 32'h3);
    idle(2);
    check(64'(irq), 64'h3, "R9 bank1 upper half");
    rd(8'h08, 32'h3, "R10 bank enable readback");

    // R7 W1C exactness
    wr(ra(0, 'h24), 32'h0000_0008);
    idle(2);
    check(64'(irq), 64'h2, "R7 R9 bank0 cleared");
    wr(ra(0, 'h24), 32'h0);
    rd(ra(0, 'h24), 32'h0010_0000, "R7 zero write keeps");
    wr(ra(0, 'h24), 32'h0010_0000);
    rd(ra(0, 'h24), 32'h0, "R7 cleared");

    // R9 set1 upper bank
    wr(ra(1, 'h14), 32'h0002_0000);
    pin_in[49] = 1;
    idle(5);
    check(64'(irq), 64'h0, "R9 bank3 disabled");
    wr(8'h08, 32'hF);
    idle(2);
    check(64'(irq), 64'h8, "R9 bank3 set1 bit17");

    // R8 collision: clear on the same edge a new edge is detected
    wr(ra(0, 'h14), 32'h0000_0010);
    wr(ra(0, 'h1C), 32'h0000_0010);
    pin_in[4] = 1;
    idle(5);
    rd(ra(0, 'h24), 32'h0000_0010, "R8 setup status");
    pin_in[4] = 0;
    idle(2);
    wr(ra(0, 'h24), 32'h0000_0010);
    rd(ra(0, 'h24), 32'h0000_0010, "R8 edge wins over clear");
    wr(ra(0, 'h24), 32'h0000_0010);
    rd(ra(0, 'h24), 32'h0, "R8 later clear works");

    idle(3);
    check(64'(exp_q.size()), 64'h0, "R10 all reads returned");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule